// File: doc/BRIEF.md
# Forbidden-Turn Reconfiguration Table

This per-router unit holds the permitted-turn table that table-based routing reads: one bit for every combination of input direction and output direction. A 1 means that a packet arriving on that input may leave on that output. A 0 means the turn is forbidden. The table has a fixed size, set by the router's port count, and does not grow with the network.

During a deadlock-removal pass the unit takes part in repeated iterations. A spanning-tree search outside the unit supplies the child marks and the cut-vertex flag for each iteration. The unit counts its live neighbours with one comparator per port. On an iteration pulse it decides whether it is the node to withdraw in this iteration. It is chosen if it is a leaf of the tree, or if it is not a cut vertex and its degree equals the minimal degree. When chosen, it forbids every turn through itself in both directions of each neighbour pair. It tells its live neighbours to drop it, requests a fresh tree search, and keeps the iteration index as its removal label.

Iterations go on while the connected subgraph still holds more than two vertices. A full reconfiguration start reloads the neighbour state and reopens the table.

Top module: `turnGuard`

## Requirements
- R1: One cycle after `cfgStart`, `validMask` equals `linkOk`, `removed` is 0, `removeLabel` is 0, and table bit `turnTable[i*NPORT+o]` is 1 exactly when i differs from o and both `linkOk[i]` and `linkOk[o]` are 1. After `rstN` is released and before any start, the table, `validMask` and `degree` are all 0.
- R2: A U-turn entry, where input i equals output o, is always 0.
- R3: `degree` always equals the number of 1 bits in `validMask`.
- R4: An iteration pulse that is accepted selects a node whose live ports include no port marked in `childMask` (a leaf). One cycle later `removed` is 1 and every table bit is 0.
- R5: An accepted pulse also selects a node with `cutVertex` 0 whose degree equals `MIN_DEG` (2). A node that is neither a leaf nor such a node is not selected, and its table stays unchanged.
- R6: The table is always symmetric: bit (i,o) equals bit (o,i), so forbidden turns always come in pairs.
- R7: In the cycle after selection, `withdrawOut` equals the live ports as they were at selection and `searchReq` is 1. Both return to 0 one cycle later.
- R8: `removeLabel` takes the number of accepted iteration pulses since the last start, counting the selecting pulse itself.
- R9: An iteration pulse is accepted only while `subgraphSize` is greater than 2. Any other pulse neither selects the node nor advances the iteration count.
- R10: A pulse on `nbrWithdraw[p]` clears `validMask[p]` and every table bit in row p and column p. No table bit is 1 unless both of its ports are live.
- R11: Once removed, the node ignores `iterPulse` and `nbrWithdraw`. Its table, live ports and label stay fixed until the next `cfgStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgStart | input | 1 | Full reconfiguration start; reloads neighbour state and table |
| linkOk | input | NPORT | Per-port neighbour health, sampled on `cfgStart` |
| nbrWithdraw | input | NPORT | Per-port pulse: that neighbour has withdrawn |
| childMask | input | NPORT | Ports marked as children by the tree search |
| cutVertex | input | 1 | Tree search found this node to be a cut vertex |
| subgraphSize | input | SIZE_W | Vertex count of the current connected subgraph |
| iterPulse | input | 1 | Selection pulse for the current iteration |
| turnTable | output | NPORT*NPORT | Permitted-turn table, bit in*NPORT+out |
| validMask | output | NPORT | Live neighbour ports |
| degree | output | $clog2(NPORT+1) | Count of live neighbour ports |
| withdrawOut | output | NPORT | One-cycle pulse telling live neighbours to drop this node |
| searchReq | output | 1 | One-cycle request for a new tree search |
| removed | output | 1 | Node has been withdrawn in this pass |
| removeLabel | output | LABEL_W | Iteration index at which the node was withdrawn |

## Verification
A corrupted live-port register shows on the very next cycle in three places: in `degree`, in table rows and columns that open or close against `linkOk`, and in a withdrawal pulse that goes to the wrong ports. A faulty selection decision shows one cycle after the pulse as a wrong `removed` flag or a table that is still open. A drifting iteration count shows up only later, as a wrong label at the moment of removal. For that reason the label sequences mix accepted, refused and non-selecting pulses before the selecting one.

// File: rtl/turnGuardPkg.sv
package turnGuardPkg;
  // Strobes from control to datapath; at most one acts per cycle, load first.
  typedef struct packed {
    logic load;    // reopen table from linkOk
    logic retire;  // close all pair turns, emit withdrawal
    logic dropEn;  // honour neighbour withdrawals
  } tgStrobe_t;
endpackage

// File: rtl/turnGuardPath.sv
module turnGuardPath
  import turnGuardPkg::*;
#(
  parameter int NPORT = 4,
  parameter int DEG_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tgStrobe_t              strobe,
  input  logic [NPORT-1:0]       linkOk,
  input  logic [NPORT-1:0]       nbrWithdraw,
  input  logic [NPORT-1:0]       childMask,
  output logic [NPORT*NPORT-1:0] turnTable,
  output logic [NPORT-1:0]       validMask,
  output logic [DEG_W-1:0]       degree,
  output logic                   isLeaf,
  output logic [NPORT-1:0]       withdrawOut
);
  localparam int TBL_W = NPORT * NPORT;

  logic [NPORT-1:0] validReg;
  logic [TBL_W-1:0] tableReg;
  logic [NPORT-1:0] withdrawReg;
  logic [TBL_W-1:0] freshTable;
  logic [TBL_W-1:0] pairMask;
  logic [TBL_W-1:0] dropMask;
  logic [DEG_W-1:0] portHit [NPORT];

  // Per-entry masks: fresh open table, pair turns through this node, drops.
  for (genvar gi = 0; gi < NPORT; gi++) begin : gRow
    for (genvar go = 0; go < NPORT; go++) begin : gCol
      if (gi == go) begin : gUturn
        assign freshTable[gi*NPORT+go] = 1'b0;
        assign pairMask[gi*NPORT+go]   = 1'b0;
      end else begin : gTurn
        assign freshTable[gi*NPORT+go] = linkOk[gi] & linkOk[go];
        assign pairMask[gi*NPORT+go]   = validReg[gi] & validReg[go];
      end
      assign dropMask[gi*NPORT+go] = nbrWithdraw[gi] | nbrWithdraw[go];
    end
    // One comparator per port feeds the degree sum.
    assign portHit[gi] = (validReg[gi] == 1'b1) ? DEG_W'(1) : DEG_W'(0);
  end

  always_comb begin
    degree = '0;
    for (int p = 0; p < NPORT; p++) degree = degree + portHit[p];
  end

  assign isLeaf = ((childMask & validReg) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validReg    <= '0;
      tableReg    <= '0;
      withdrawReg <= '0;
    end else begin
      withdrawReg <= '0;
      if (strobe.load) begin
        validReg <= linkOk;
        tableReg <= freshTable;
      end else if (strobe.retire) begin
        tableReg    <= tableReg & ~pairMask;
        withdrawReg <= validReg;
      end else if (strobe.dropEn) begin
        validReg <= validReg & ~nbrWithdraw;
        tableReg <= tableReg & ~dropMask;
      end
    end
  end

  assign turnTable   = tableReg;
  assign validMask   = validReg;
  assign withdrawOut = withdrawReg;
endmodule

// File: rtl/turnGuardCtrl.sv
module turnGuardCtrl
  import turnGuardPkg::*;
#(
  parameter int DEG_W   = 3,
  parameter int SIZE_W  = 8,
  parameter int LABEL_W = 6,
  parameter int MIN_DEG = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgStart,
  input  logic               iterPulse,
  input  logic [SIZE_W-1:0]  subgraphSize,
  input  logic               cutVertex,
  input  logic               isLeaf,
  input  logic [DEG_W-1:0]   degree,
  output tgStrobe_t          strobe,
  output logic               removed,
  output logic [LABEL_W-1:0] removeLabel,
  output logic               searchReq
);
  localparam logic [SIZE_W-1:0] STOP_SIZE = SIZE_W'(2);
  localparam logic [DEG_W-1:0]  MIN_D     = DEG_W'(MIN_DEG);

  logic [LABEL_W-1:0] iterCount;
  logic               removedReg;
  logic               accept;
  logic               pick;

  assign accept = iterPulse && !cfgStart && (subgraphSize > STOP_SIZE);
  assign pick   = accept && !removedReg &&
                  (isLeaf || (!cutVertex && degree == MIN_D));

  always_comb begin
    strobe.load   = cfgStart;
    strobe.retire = pick;
    strobe.dropEn = !cfgStart && !removedReg && !pick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iterCount   <= '0;
      removedReg  <= 1'b0;
      removeLabel <= '0;
      searchReq   <= 1'b0;
    end else if (cfgStart) begin
      iterCount   <= '0;
      removedReg  <= 1'b0;
      removeLabel <= '0;
      searchReq   <= 1'b0;
    end else begin
      searchReq <= pick;
      if (accept) iterCount <= iterCount + LABEL_W'(1);
      if (pick) begin
        removedReg  <= 1'b1;
        removeLabel <= iterCount + LABEL_W'(1);
      end
    end
  end

  assign removed = removedReg;
endmodule

// File: rtl/turnGuard.sv
module turnGuard
  import turnGuardPkg::*;
#(
  parameter int NPORT   = 4,
  parameter int SIZE_W  = 8,
  parameter int LABEL_W = 6,
  parameter int MIN_DEG = 2,
  localparam int DEG_W  = $clog2(NPORT + 1),
  localparam int TBL_W  = NPORT * NPORT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgStart,
  input  logic [NPORT-1:0]   linkOk,
  input  logic [NPORT-1:0]   nbrWithdraw,
  input  logic [NPORT-1:0]   childMask,
  input  logic               cutVertex,
  input  logic [SIZE_W-1:0]  subgraphSize,
  input  logic               iterPulse,
  output logic [TBL_W-1:0]   turnTable,
  output logic [NPORT-1:0]   validMask,
  output logic [DEG_W-1:0]   degree,
  output logic [NPORT-1:0]   withdrawOut,
  output logic               searchReq,
  output logic               removed,
  output logic [LABEL_W-1:0] removeLabel
);
  tgStrobe_t strobe;
  logic      isLeaf;

  turnGuardCtrl #(
    .DEG_W(DEG_W), .SIZE_W(SIZE_W), .LABEL_W(LABEL_W), .MIN_DEG(MIN_DEG)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .iterPulse(iterPulse),
    .subgraphSize(subgraphSize), .cutVertex(cutVertex), .isLeaf(isLeaf),
    .degree(degree), .strobe(strobe), .removed(removed),
    .removeLabel(removeLabel), .searchReq(searchReq)
  );

  turnGuardPath #(.NPORT(NPORT), .DEG_W(DEG_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkOk(linkOk),
    .nbrWithdraw(nbrWithdraw), .childMask(childMask), .turnTable(turnTable),
    .validMask(validMask), .degree(degree), .isLeaf(isLeaf),
    .withdrawOut(withdrawOut)
  );
endmodule

// File: rtl/turnGuardChecker.sv
module turnGuardChecker #(
  parameter int NPORT   = 4,
  parameter int LABEL_W = 6,
  parameter int DEG_W   = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgStart,
  input logic [NPORT*NPORT-1:0] turnTable,
  input logic [NPORT-1:0]       validMask,
  input logic [DEG_W-1:0]       degree,
  input logic [NPORT-1:0]       withdrawOut,
  input logic                   searchReq,
  input logic                   removed,
  input logic [LABEL_W-1:0]     removeLabel
);
  logic [NPORT*NPORT-1:0] diagMask;
  logic [NPORT*NPORT-1:0] mirror;
  logic [NPORT*NPORT-1:0] liveMask;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        diagMask[i*NPORT+o] = (i == o);
        mirror[i*NPORT+o]   = turnTable[o*NPORT+i];
        liveMask[i*NPORT+o] = validMask[i] & validMask[o];
      end
    end
  end

  assert_no_uturn_R2: assert property (@(posedge clk) disable iff (!rstN)
    (turnTable & diagMask) == '0);

  assert_pair_symmetric_R6: assert property (@(posedge clk) disable iff (!rstN)
    turnTable == mirror);

  assert_turns_need_live_ports_R10: assert property (@(posedge clk) disable iff (!rstN)
    (turnTable & ~liveMask) == '0);

  assert_degree_matches_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    degree == DEG_W'($countones(validMask)));

  assert_search_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    searchReq |=> !searchReq);

  assert_withdraw_with_search_R7: assert property (@(posedge clk) disable iff (!rstN)
    (withdrawOut != '0) |-> searchReq);

  assert_retired_table_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    searchReq |-> (removed && turnTable == '0));

  assert_removed_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (removed && !cfgStart) |=> (removed && $stable(turnTable) &&
                                $stable(validMask) && $stable(removeLabel)));
endmodule

bind turnGuard turnGuardChecker #(
  .NPORT(NPORT), .LABEL_W(LABEL_W), .DEG_W(DEG_W)
) uChk (
  .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .turnTable(turnTable),
  .validMask(validMask), .degree(degree), .withdrawOut(withdrawOut),
  .searchReq(searchReq), .removed(removed), .removeLabel(removeLabel)
);

// File: tb/tb_turnGuard.sv
module tb_turnGuard;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgStart = 1'b0;
  logic [3:0]  linkOk = '0;
  logic [3:0]  nbrWithdraw = '0;
  logic [3:0]  childMask = '0;
  logic        cutVertex = 1'b0;
  logic [7:0]  subgraphSize = 8'd8;
  logic        iterPulse = 1'b0;
  logic [15:0] turnTable;
  logic [3:0]  validMask;
  logic [2:0]  degree;
  logic [3:0]  withdrawOut;
  logic        searchReq;
  logic        removed;
  logic [5:0]  removeLabel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  turnGuard dut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .linkOk(linkOk),
    .nbrWithdraw(nbrWithdraw), .childMask(childMask), .cutVertex(cutVertex),
    .subgraphSize(subgraphSize), .iterPulse(iterPulse), .turnTable(turnTable),
    .validMask(validMask), .degree(degree), .withdrawOut(withdrawOut),
    .searchReq(searchReq), .removed(removed), .removeLabel(removeLabel)
  );

  function automatic logic [15:0] openTable(input logic [3:0] v);
    logic [15:0] t;
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++)
        t[i*NP+o] = (i != o) && v[i] && v[o];
    return t;
  endfunction

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < NP; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after a falling edge; outputs settle by the next falling edge.
  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic startCfg(input logic [3:0] ok);
    linkOk = ok; cfgStart = 1'b1;
    cycle();
    cfgStart = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] size);
    subgraphSize = size; iterPulse = 1'b1;
    cycle();
    iterPulse = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    cycle();
    check("R1 reset", {turnTable, validMask, 1'b0, degree, removed}, 64'd0);
    rstN = 1'b1;
    cycle();

    // R1 R3: every health pattern on start
    for (int v = 0; v < 16; v++) begin
      startCfg(4'(v));
      check("R1 table", turnTable, openTable(4'(v)));
      check("R1 state", {validMask, removed, removeLabel}, {4'(v), 1'b0, 6'd0});
      check("R3 degree", degree, 64'(ones(4'(v))));
    end

    // R4 R5 R7: exhaustive selection sweep
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 16; c++) begin
        for (int k = 0; k < 2; k++) begin
          logic sel;
          sel = ((4'(c) & 4'(v)) == 4'd0) || (k == 0 && ones(4'(v)) == 2);
          startCfg(4'(v));
          childMask = 4'(c); cutVertex = k[0];
          pulse(8'd8);
          check(sel ? "R4 R7 select" : "R5 keep",
                {turnTable, withdrawOut, searchReq, removed, removeLabel},
                {sel ? 16'd0 : openTable(4'(v)), sel ? 4'(v) : 4'd0,
                 sel, sel, sel ? 6'd1 : 6'd0});
          cycle();
          check("R7 pulse ends", {withdrawOut, searchReq}, 64'd0);
        end
      end
    end

    // R8 R9: label counts only accepted pulses
    startCfg(4'b1111);
    childMask = 4'b0001; cutVertex = 1'b1;
    for (int n = 0; n < 3; n++) pulse(8'd8);
    for (int n = 0; n < 2; n++) pulse(8'd2);
    check("R8 not yet", {removed, removeLabel}, 64'd0);
    childMask = 4'b0000;
    pulse(8'd9);
    check("R8 label", {removed, removeLabel}, {1'b1, 6'd4});

    startCfg(4'b0011);
    childMask = 4'b0000;
    pulse(8'd2);
    check("R9 refused", {removed, turnTable}, {1'b0, openTable(4'b0011)});
    pulse(8'd3);
    check("R9 accepted", {removed, removeLabel}, {1'b1, 6'd1});

    // R10: neighbour withdrawal closes row and column
    startCfg(4'b1111);
    childMask = 4'b0001; cutVertex = 1'b0;
    nbrWithdraw = 4'b0100; cycle(); nbrWithdraw = 4'b0000;
    check("R10 drop", {validMask, degree, turnTable},
          {4'b1011, 3'd3, openTable(4'b1011)});
    pulse(8'd8);
    check("R5 degree3", removed, 64'd0);
    nbrWithdraw = 4'b0001; cycle(); nbrWithdraw = 4'b0000;
    check("R10 drop2", {validMask, degree}, {4'b1010, 3'd2});
    pulse(8'd8);
    check("R7 withdraw", {withdrawOut, removed, removeLabel}, {4'b1010, 1'b1, 6'd2});

    // R11: removed node frozen
    cycle();
    nbrWithdraw = 4'b1000; cycle(); nbrWithdraw = 4'b0000;
    pulse(8'd8);
    check("R11 frozen", {validMask, removeLabel, searchReq, turnTable},
          {4'b1010, 6'd2, 1'b0, 16'd0});
    startCfg(4'b0110);
    check("R11 restart", {removed, validMask, turnTable},
          {1'b0, 4'b0110, openTable(4'b0110)});

    finishRun();
  end
endmodule